// File: doc/BRIEF.md
# SPI Controller Status Flags

This block keeps the read-only status word of an SPI controller. It follows how full the transmit and receive buffers are, spots a mode fault (another master pulling the select line low while this controller is a master), and shows whether an outside master has selected the controller as a slave. Host-side strobes come from the register bus. Transfer-complete pulses come from the shift engine. The select pin and a master/slave configuration bit are sampled directly.

A build-time switch picks one of two buffering styles. In FIFO style, saturating occupancy counters stand in for the transmit and receive FIFOs. In single-register style, each buffer is a one-entry holding register whose full and empty flags follow a set/clear handshake. The status word is built from registered flags. A mode fault also raises a one-clock interrupt strobe.

Top module: `spi_stat_word`

## Requirements
- R1: Layout of `stat_word`. Bits [31:6] read 0. Bit 5 is slave-selected (active low). Bit 4 is mode fault, bit 3 transmit full, bit 2 transmit empty, bit 1 receive full and bit 0 receive empty. In MSB-first numbering these six flags are bits 26 to 31.
- R2: After reset `stat_word` reads 0x25 and `modf_irq` is 0.
- R3: One clock after sampling, bit 5 is 0 only if `cfg_master`=0 and `ss_n`=0. In every other case it is 1.
- R4: If `ss_n` is sampled going from 1 to 0 while `cfg_master`=1, bit 4 is 1 from the next clock. It then stays set until a status read.
- R5: A status read (`stat_rd`) clears bit 4 on the next clock. If a new mode-fault event happens in the same cycle, the bit stays 1 and a strobe is still issued.
- R6: `modf_irq` is high for exactly one clock, in the same cycle that bit 4 is first seen set by a new event.
- R7: FIFO style, transmit side. The count rises on `host_tx_wr` and falls on `xfer_done`. Bit 3 is 1 when the count equals FIFO_DEPTH, and bit 2 is 1 when the count is 0.
- R8: FIFO style, receive side. The count rises on `xfer_done` and falls on `host_rx_rd`. Bit 1 is 1 at FIFO_DEPTH, and bit 0 is 1 at 0.
- R9: FIFO style. An increment and a decrement in the same cycle leave the count unchanged. Increments at FIFO_DEPTH and decrements at 0 have no effect.
- R10: Single-register style, transmit side. `host_tx_wr` gives bit 3=1 and bit 2=0. `xfer_done` gives bit 3=0 and bit 2=1. When both happen in one cycle, the write wins.
- R11: Single-register style, receive side. `xfer_done` gives bit 1=1 and bit 0=0. `host_rx_rd` gives bit 1=0 and bit 0=1. When both happen in one cycle, the transfer wins. Bits 1 and 0 are always complements.
- R12: A host write to the status word (`stat_wr`) changes no bit of `stat_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_tx_wr | input | 1 | Host write to the transmit register or FIFO |
| host_rx_rd | input | 1 | Host read of the receive register or FIFO |
| stat_rd | input | 1 | Host read of the status word |
| stat_wr | input | 1 | Host write to the status word (ignored) |
| xfer_done | input | 1 | One-cycle pulse from the shift engine at the end of a transfer |
| ss_n | input | 1 | Slave-select pin, active low |
| cfg_master | input | 1 | 1 = master configuration, 0 = slave |
| stat_word | output | 32 | Status word |
| modf_irq | output | 1 | One-clock mode-fault interrupt strobe |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy uses FIFO style with FIFO_DEPTH=4. The other uses single-register style. The small depth lets a handful of strobes reach the full mark, so saturation at the top and bottom and the combined increment/decrement case can all be checked in a few cycles. The single-register copy exposes the precedence between simultaneous set and clear. The mode-fault sequence includes a status read that lands in the same cycle as a new fault.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
   localparam int STAT_W = 32;

   // LSB-first positions of the flags inside the status word
   localparam int POS_RX_EMPTY = 0;
   localparam int POS_RX_FULL  = 1;
   localparam int POS_TX_EMPTY = 2;
   localparam int POS_TX_FULL  = 3;
   localparam int POS_MODF     = 4;
   localparam int POS_SEL_N    = 5;
   localparam int FLAG_CNT     = 6;

   typedef struct packed {
      logic sel_n;
      logic modf;
      logic tx_full;
      logic tx_empty;
      logic rx_full;
      logic rx_empty;
   } stat_flags_t;
endpackage

// File: rtl/spi_stat_occ.sv
module spi_stat_occ #(
   parameter bit USE_FIFO = 1'b1,
   parameter int DEPTH    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic pop,
   output logic full,
   output logic empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_stat_occ: DEPTH must be at least 2");
   end

   if (USE_FIFO) begin : g_fifo
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      always_comb begin
         cnt_d = cnt_q;
         if (push && !pop && (cnt_q != CNT_W'(DEPTH)))
            cnt_d = cnt_q + CNT_W'(1);
         else if (pop && !push && (cnt_q != '0))
            cnt_d = cnt_q - CNT_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_d;
      end

      assign full  = (cnt_q == CNT_W'(DEPTH));
      assign empty = (cnt_q == '0);

      AST_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         push && !pop |=> !empty); // R9
      AST_POP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         pop && !push |=> !full); // R9
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !push && !pop |=> $stable(full) && $stable(empty)); // R7
   end else begin : g_reg
      logic full_q;
      logic empty_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
         end else if (push) begin
            full_q  <= 1'b1;
            empty_q <= 1'b0;
         end else if (pop) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
         end
      end

      assign full  = full_q;
      assign empty = empty_q;

      AST_REG_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
         full != empty); // R11
      AST_REG_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         push |=> full); // R10
   end

   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R8
endmodule

// File: rtl/spi_stat_modf.sv
module spi_stat_modf (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n,
   input  logic cfg_master,
   input  logic stat_rd,
   output logic sel_n,
   output logic modf,
   output logic irq
);
   logic ss_prev_q;
   logic sel_n_q;
   logic modf_q;
   logic irq_q;
   logic fault_ev;

   // select line newly pulled low by someone else while acting as master
   assign fault_ev = cfg_master && !ss_n && ss_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_prev_q <= 1'b1;
         sel_n_q   <= 1'b1;
         modf_q    <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         ss_prev_q <= ss_n;
         sel_n_q   <= cfg_master || ss_n;
         if (fault_ev)     modf_q <= 1'b1;
         else if (stat_rd) modf_q <= 1'b0;
         irq_q <= fault_ev && (!modf_q || stat_rd);
      end
   end

   assign sel_n = sel_n_q;
   assign modf  = modf_q;
   assign irq   = irq_q;

   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> modf); // R6
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R6
   AST_MODF_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && !(cfg_master && !ss_n && ss_prev_q) |=> !modf); // R5
   AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      modf && !stat_rd |=> modf); // R4
   AST_SEL_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master |=> sel_n); // R3
endmodule

// File: rtl/spi_stat_word.sv
module spi_stat_word
   import spi_stat_pkg::*;
#(
   parameter bit USE_FIFO   = 1'b1,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_tx_wr,
   input  logic              host_rx_rd,
   input  logic              stat_rd,
   input  logic              stat_wr,
   input  logic              xfer_done,
   input  logic              ss_n,
   input  logic              cfg_master,
   output logic [STAT_W-1:0] stat_word,
   output logic              modf_irq
);
   localparam int RSVD_W = STAT_W - FLAG_CNT;

   if (STAT_W < FLAG_CNT) begin : g_bad_width
      $error("spi_stat_word: status width too small for the flags");
   end

   stat_flags_t flags;

   spi_stat_occ #(.USE_FIFO(USE_FIFO), .DEPTH(FIFO_DEPTH)) u_tx_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (host_tx_wr),
      .pop   (xfer_done),
      .full  (flags.tx_full),
      .empty (flags.tx_empty)
   );

   spi_stat_occ #(.USE_FIFO(USE_FIFO), .DEPTH(FIFO_DEPTH)) u_rx_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (xfer_done),
      .pop   (host_rx_rd),
      .full  (flags.rx_full),
      .empty (flags.rx_empty)
   );

   spi_stat_modf u_modf (
      .clk        (clk),
      .rst_n      (rst_n),
      .ss_n       (ss_n),
      .cfg_master (cfg_master),
      .stat_rd    (stat_rd),
      .sel_n      (flags.sel_n),
      .modf       (flags.modf),
      .irq        (modf_irq)
   );

   // stat_wr is deliberately not connected to any state
   assign stat_word = {{RSVD_W{1'b0}}, flags};

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[STAT_W-1:FLAG_CNT] == '0); // R1
   AST_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && !host_tx_wr && !host_rx_rd && !xfer_done && !stat_rd && !cfg_master
      |=> $stable(stat_word[POS_MODF:POS_RX_EMPTY])); // R12
endmodule

// File: tb/spi_stat_word_tb.sv
module spi_stat_word_tb;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_tx_wr = 1'b0, host_rx_rd = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0;
   logic xfer_done = 1'b0, ss_n = 1'b1, cfg_master = 1'b1;
   logic [31:0] word_f, word_s;
   logic irq_f, irq_s;

   always #4 clk = ~clk; // 8 ns period, 125 MHz

   spi_stat_word #(.USE_FIFO(1'b1), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
      .stat_rd(stat_rd), .stat_wr(stat_wr), .xfer_done(xfer_done), .ss_n(ss_n),
      .cfg_master(cfg_master), .stat_word(word_f), .modf_irq(irq_f));

   spi_stat_word #(.USE_FIFO(1'b0), .FIFO_DEPTH(DEPTH)) u_dut_single (
      .clk(clk), .rst_n(rst_n), .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
      .stat_rd(stat_rd), .stat_wr(stat_wr), .xfer_done(xfer_done), .ss_n(ss_n),
      .cfg_master(cfg_master), .stat_word(word_s), .modf_irq(irq_s));

   typedef struct {
      string       tag;
      logic [31:0] wf;
      logic [31:0] ws;
      logic        irq;
   } exp_t;

   exp_t sb_q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   int   m_tx = 0, m_rx = 0;
   bit   s_txf = 0, s_txe = 1, s_rxf = 0;
   bit   m_sel = 1, m_modf = 0, m_ssp = 1;

   function automatic logic [31:0] mk(bit s, bit m, bit tf, bit te, bit rf, bit re);
      return {26'b0, s, m, tf, te, rf, re};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, bit tw, bit rr, bit dn, bit sr, bit sw,
                       bit ssn, bit mst);
      exp_t e;
      bit ev, irq;
      int nt, nr;
      @(negedge clk);
      host_tx_wr = tw; host_rx_rd = rr; xfer_done = dn;
      stat_rd = sr; stat_wr = sw; ss_n = ssn; cfg_master = mst;
      ev  = mst && !ssn && m_ssp;
      irq = ev && (!m_modf || sr);
      m_modf = ev ? 1'b1 : (sr ? 1'b0 : m_modf);
      m_sel = mst || ssn;
      m_ssp = ssn;
      nt = m_tx + int'(tw) - int'(dn);
      nr = m_rx + int'(dn) - int'(rr);
      m_tx = (nt < 0) ? 0 : ((nt > DEPTH) ? DEPTH : nt);
      m_rx = (nr < 0) ? 0 : ((nr > DEPTH) ? DEPTH : nr);
      if (tw) begin s_txf = 1; s_txe = 0; end
      else if (dn) begin s_txf = 0; s_txe = 1; end
      if (dn) s_rxf = 1;
      else if (rr) s_rxf = 0;
      e.tag = tag;
      e.irq = irq;
      e.wf = mk(m_sel, m_modf, m_tx == DEPTH, m_tx == 0, m_rx == DEPTH, m_rx == 0);
      e.ws = mk(m_sel, m_modf, s_txf, s_txe, s_rxf, !s_rxf);
      sb_q.push_back(e);
      @(posedge clk);
   endtask

   // monitor: compare one scoreboard entry after each active edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(e.tag, "fifo word", word_f, e.wf);
         chk(e.tag, "single word", word_s, e.ws);
         chk(e.tag, "fifo irq", {31'b0, irq_f}, {31'b0, e.irq});
         chk(e.tag, "single irq", {31'b0, irq_s}, {31'b0, e.irq});
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      chk("R2", "reset fifo word", word_f, 32'h25);
      chk("R2", "reset single word", word_s, 32'h25);
      chk("R2", "reset irq", {31'b0, irq_f}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R12: status writes alone change nothing
      step("R12", 0, 0, 0, 0, 1, 1, 0);
      step("R12", 0, 0, 0, 0, 1, 1, 0);
      // R3 and R1: slave selected only in slave configuration with ss_n low
      step("R3", 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 0, 1, 0, 0);
      step("R3", 0, 0, 0, 0, 0, 1, 0);
      step("R1", 0, 0, 0, 0, 0, 1, 1);
      // R4/R6: mode fault while master
      step("R4", 0, 0, 0, 0, 0, 0, 1);
      step("R6", 0, 0, 0, 0, 0, 0, 1);
      step("R4", 0, 0, 0, 0, 0, 1, 1);
      // R5: read clears
      step("R5", 0, 0, 0, 1, 0, 1, 1);
      step("R4", 0, 0, 0, 0, 0, 0, 1);
      step("R5", 0, 0, 0, 0, 0, 1, 1);
      // R5: read in the same cycle as a new fault keeps the flag and strobes
      step("R5", 0, 0, 0, 1, 0, 0, 1);
      step("R5", 0, 0, 0, 1, 0, 1, 1);
      // R7/R9/R10: transmit fill beyond depth
      for (int i = 0; i < DEPTH + 1; i++) step("R7", 1, 0, 0, 0, 0, 1, 1);
      step("R9", 1, 0, 1, 0, 0, 1, 1);
      // R7/R8/R11: drain transmit, fill receive
      for (int i = 0; i < DEPTH + 1; i++) step("R8", 0, 0, 1, 0, 0, 1, 1);
      step("R9", 0, 1, 1, 0, 0, 1, 1);
      // R11: drain receive beyond empty
      for (int i = 0; i < DEPTH + 1; i++) step("R11", 0, 1, 0, 0, 0, 1, 1);
      // R10: write and done together, write wins in single style
      step("R10", 1, 0, 1, 0, 0, 1, 1);
      step("R10", 0, 0, 1, 0, 0, 1, 1);
      // R11: done and read together, transfer wins
      step("R11", 0, 1, 1, 0, 0, 1, 1);
      step("R9", 0, 0, 0, 0, 1, 1, 0);
      step("R11", 0, 1, 0, 0, 0, 1, 1);
      step("R12", 0, 0, 0, 0, 1, 1, 1);
      @(negedge clk);
      host_tx_wr = 0; host_rx_rd = 0; xfer_done = 0; stat_rd = 0; stat_wr = 0;
      @(posedge clk);
      #2;
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule